// File: doc/BRIEF.md
# Per-Master Bus Error Status Capture

This block keeps the error status of a shared bus that serves between 1 and 32 masters. Each status register has one bit for each master: bit i belongs to master i. When the bus fabric reports a failed transfer, it presents the failing master's index together with two flags: whether the transfer was a read, and whether the fields should be frozen. The block then records that an error happened, the transfer direction and the freeze request for that master.

While a master's lock bit is set, its captured fields ignore later errors. This keeps the first failure for software until software clears it. Software reaches the status through a small synchronous register port. Read data appears one cycle after the read strobe.

The port decodes four word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | error-detect | write 1 to clear |
| 1 | read/write type | read only |
| 2 | lock | read only |
| 3 | control | bit 0 is a self-clearing soft reset |

A system reset input and the soft-reset bit both return every status bit to zero.

Top module: `bus_err_status`

## Requirements
- R1: While `sys_rst` is high, and after it falls, every status register reads zero and `reg_rdata` is zero. A `sys_rst` asserted in the middle of operation clears all captured state.
- R2: An error event (`err_valid` high) for master m < NUM_MASTERS, when that master's lock bit is clear, sets detect bit m. The same clock edge loads rnw bit m from `err_read` (1 means read, 0 means write) and lock bit m from `err_lock`.
- R3: While lock bit m is clear, each new error event for master m overwrites its rnw and lock bits with the new event's flags.
- R4: While lock bit m is set, an error event for master m leaves its detect, rnw and lock bits unchanged, unless the same cycle also clears detect bit m. A lock bit is never set while its detect bit is clear.
- R5: Writing to address 0 clears the detect, rnw and lock bits of every master whose `reg_wdata` bit is 1. Bits written as 0 leave their master's state unchanged.
- R6: If an error event for master m arrives in the same cycle as a write-1 clear of detect bit m, the new event is captured with its own flags, even when lock bit m was set.
- R7: Writes to address 1 (rnw) and address 2 (lock) change no state.
- R8: Writing a 1 to bit 0 of address 3 clears every status bit at that clock edge. An error event in the same cycle is discarded. Address 3 always reads as zero.
- R9: A read strobe at edge t places the selected register, as it stood before edge t, on `reg_rdata` from edge t until the next edge. If no read strobe occurs at an edge, `reg_rdata` is zero after it. Bits NUM_MASTERS and above are always zero.
- R10: An error event whose master index is NUM_MASTERS or higher changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous system reset, active high |
| err_valid | input | 1 | Error event strobe |
| err_master | input | IDX_W | Index of the failing master |
| err_read | input | 1 | 1 when the failing transfer was a read |
| err_lock | input | 1 | 1 to freeze this master's fields after capture |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after `reg_rd` |

## Verification
The bench builds the block with NUM_MASTERS = 5 and the default 32-bit data width. With these values the 3-bit master index can name masters 5 to 7, which do not exist, so the out-of-range events of R10 can be driven. Bits 5 to 31 of every register are also unused, so the zero-fill of R9 is visible. The last valid master, index 4, sits at the edge of the used field. Lock freezing, the same-cycle clash between an event and a clear, and soft reset against a coincident event are each driven on chosen masters, while the other masters keep their state.

// File: rtl/bus_err_status_pkg.sv
package bus_err_status_pkg;

    // Register word addresses of the software port
    typedef enum logic [1:0] {
        RA_DETECT = 2'd0,
        RA_RDFLAG = 2'd1,
        RA_LOCK   = 2'd2,
        RA_CTRL   = 2'd3
    } reg_addr_e;

    // Captured fields of one master
    typedef struct packed {
        logic det;
        logic rnw;
        logic lck;
    } slot_t;

    localparam int CTRL_SRST_BIT = 0;

endpackage

// File: rtl/bes_slot.sv
module bes_slot
    import bus_err_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic srst,
    input  logic ev_read,
    input  logic ev_lock,
    output logic det,
    output logic rnw,
    output logic lck
);

    slot_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (srst) begin
            nxt_d = '0;
        end else begin
            if (clr) begin
                nxt_d = '0;
            end
            if (hit && (!cur_q.lck || clr)) begin
                nxt_d.det = 1'b1;
                nxt_d.rnw = ev_read;
                nxt_d.lck = ev_lock;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign det = cur_q.det;
    assign rnw = cur_q.rnw;
    assign lck = cur_q.lck;

    // R2 / R3: an accepted event loads its own flags
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && !srst && (!cur_q.lck || clr)) |=>
            (cur_q.det && cur_q.rnw == $past(ev_read) && cur_q.lck == $past(ev_lock)))
        else $error("p_capture_r2");

    // R4: locked fields are frozen against a new event
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && cur_q.lck && !clr && !srst) |=> $stable(cur_q))
        else $error("p_lock_hold_r4");

    // R4: lock never set without a detected error
    p_lock_det_r4: assert property (@(posedge clk) disable iff (rst)
        cur_q.lck |-> cur_q.det)
        else $error("p_lock_det_r4");

    // R5: a clear with no competing event empties the slot
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit && !srst) |=> (cur_q == '0))
        else $error("p_clear_r5");

    // R8: soft reset empties the slot
    p_srst_r8: assert property (@(posedge clk) disable iff (rst)
        srst |=> (cur_q == '0))
        else $error("p_srst_r8");

endmodule

// File: rtl/bes_readback.sv
module bes_readback
    import bus_err_status_pkg::*;
#(
    parameter int NUM_MASTERS = 8,
    parameter int DATA_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd,
    input  logic [1:0]             addr,
    input  logic [NUM_MASTERS-1:0] det_vec,
    input  logic [NUM_MASTERS-1:0] rnw_vec,
    input  logic [NUM_MASTERS-1:0] lck_vec,
    output logic [DATA_W-1:0]      rdata
);

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    always_comb begin
        word = '0;
        unique case (reg_addr_e'(addr))
            RA_DETECT: word[NUM_MASTERS-1:0] = det_vec;
            RA_RDFLAG: word[NUM_MASTERS-1:0] = rnw_vec;
            RA_LOCK:   word[NUM_MASTERS-1:0] = lck_vec;
            default:   word = '0;
        endcase
        rdata_d = rd ? word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R9: no strobe, no data
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == '0))
        else $error("p_idle_zero_r9");

    // R8: control register never returns a set bit
    p_ctrl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 2'd3) |=> (rdata == '0))
        else $error("p_ctrl_zero_r8");

    generate
        if (NUM_MASTERS < DATA_W) begin : g_unused
            // R9: bits above the last master stay zero
            p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
                rdata[DATA_W-1:NUM_MASTERS] == '0)
                else $error("p_unused_zero_r9");
        end
    endgenerate

endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
    import bus_err_status_pkg::*;
#(
    parameter int NUM_MASTERS = 8,    // 1 to 32, not above DATA_W
    parameter int DATA_W      = 32,
    localparam int IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              err_valid,
    input  logic [IDX_W-1:0]  err_master,
    input  logic              err_read,
    input  logic              err_lock,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [NUM_MASTERS-1:0] clr_vec;
    logic [NUM_MASTERS-1:0] hit_vec;
    logic [NUM_MASTERS-1:0] det_vec, rnw_vec, lck_vec;
    logic                   srst;

    always_comb begin
        srst    = reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL) && reg_wdata[CTRL_SRST_BIT];
        clr_vec = (reg_wr && (reg_addr_e'(reg_addr) == RA_DETECT))
                  ? reg_wdata[NUM_MASTERS-1:0] : '0;
    end

    generate
        for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_slot
            assign hit_vec[i] = err_valid && (err_master == IDX_W'(i));

            bes_slot u_slot (
                .clk     (clk),
                .rst     (sys_rst),
                .hit     (hit_vec[i]),
                .clr     (clr_vec[i]),
                .srst    (srst),
                .ev_read (err_read),
                .ev_lock (err_lock),
                .det     (det_vec[i]),
                .rnw     (rnw_vec[i]),
                .lck     (lck_vec[i])
            );
        end
    endgenerate

    bes_readback #(
        .NUM_MASTERS (NUM_MASTERS),
        .DATA_W      (DATA_W)
    ) u_readback (
        .clk     (clk),
        .rst     (sys_rst),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .det_vec (det_vec),
        .rnw_vec (rnw_vec),
        .lck_vec (lck_vec),
        .rdata   (reg_rdata)
    );

    // R7: writes to the read-only registers leave them untouched
    p_ro_rnw_r7: assert property (@(posedge clk) disable iff (sys_rst)
        (reg_wr && reg_addr == 2'd1 && !err_valid) |=> $stable(rnw_vec))
        else $error("p_ro_rnw_r7");

    p_ro_lock_r7: assert property (@(posedge clk) disable iff (sys_rst)
        (reg_wr && reg_addr == 2'd2 && !err_valid) |=> $stable(lck_vec))
        else $error("p_ro_lock_r7");

    // R10: an index past the last master touches nothing
    p_range_r10: assert property (@(posedge clk) disable iff (sys_rst)
        (err_valid && 32'(err_master) >= NUM_MASTERS && !reg_wr) |=>
            ($stable(det_vec) && $stable(rnw_vec) && $stable(lck_vec)))
        else $error("p_range_r10");

    // R1: system reset empties all status
    p_sysrst_r1: assert property (@(posedge clk)
        sys_rst |=> (det_vec == '0 && rnw_vec == '0 && lck_vec == '0 && reg_rdata == '0))
        else $error("p_sysrst_r1");

endmodule

// File: tb/bus_err_status_bench.sv
`timescale 1ns/1ps
module bus_err_status_bench;

    localparam int N  = 5;
    localparam int DW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          sys_rst;
    logic          err_valid, err_read, err_lock;
    logic [IW-1:0] err_master;
    logic          reg_wr, reg_rd;
    logic [1:0]    reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;

    int compared = 0;
    int mismatched = 0;

    // behavioural model state
    logic [31:0] mdet = '0, mrnw = '0, mlck = '0;

    always #2.5 clk = ~clk;

    bus_err_status #(.NUM_MASTERS(N), .DATA_W(DW)) u_bus_err_status (
        .clk(clk), .sys_rst(sys_rst), .err_valid(err_valid), .err_master(err_master),
        .err_read(err_read), .err_lock(err_lock), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic cyc(input logic ev, input int m, input logic rf, input logic lf,
                       input logic wr, input logic rd, input logic [1:0] a,
                       input logic [31:0] wd, input string tag);
        logic [31:0] expv, clrv;
        logic        sr;
        err_valid = ev; err_master = IW'(m); err_read = rf; err_lock = lf;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        expv = '0;
        if (!sys_rst && rd) begin
            if (a == 2'd0) expv = mdet;
            else if (a == 2'd1) expv = mrnw;
            else if (a == 2'd2) expv = mlck;
        end
        clrv = (wr && a == 2'd0) ? wd : '0;
        sr   = wr && a == 2'd3 && wd[0];
        if (sys_rst || sr) begin
            mdet = '0; mrnw = '0; mlck = '0;
        end else begin
            mdet = mdet & ~clrv; mrnw = mrnw & ~clrv; mlck = mlck & ~clrv;
            if (ev && m < N && (!mlck[m] || clrv[m])) begin
                mdet[m] = 1'b1; mrnw[m] = rf; mlck[m] = lf;
            end
        end
        @(negedge clk);
        compared++;
        if (reg_rdata !== expv) begin
            mismatched++;
            $display("FAIL %s: reg_rdata actual %h expected %h", tag, reg_rdata, expv);
        end
    endtask

    task automatic ev(input int m, input logic rf, input logic lf, input string tag);
        cyc(1'b1, m, rf, lf, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 4; a++) rd(2'(a), tag);
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        sys_rst = 1'b1;
        err_valid = 0; err_master = '0; err_read = 0; err_lock = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        @(negedge clk);
        // R1: reads during reset and right after it
        rd(2'd0, "R1"); rd(2'd1, "R1");
        sys_rst = 1'b0;
        rd_all("R1");

        // R2: read error captured, unlocked
        ev(2, 1'b1, 1'b0, "R2");
        rd_all("R2");
        // R3: unlocked overwrite with a write error
        ev(2, 1'b0, 1'b0, "R3");
        rd(2'd1, "R3"); rd(2'd0, "R3");
        ev(2, 1'b1, 1'b0, "R3");
        rd(2'd1, "R3");

        // R4: lock then ignore a later error
        ev(3, 1'b1, 1'b1, "R4");
        ev(3, 1'b0, 1'b0, "R4");
        rd_all("R4");
        ev(3, 1'b0, 1'b1, "R4");
        rd(2'd1, "R4"); rd(2'd2, "R4");

        // R5: clear master 3 only; zero bits leave master 2
        wr(2'd0, 32'h0000_0008, "R5");
        rd_all("R5");
        ev(3, 1'b0, 1'b0, "R5");
        rd(2'd0, "R5");

        // R6: locked master, event and clear in the same cycle
        ev(1, 1'b1, 1'b1, "R6");
        cyc(1'b1, 1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0000_0002, "R6");
        rd_all("R6");

        // R7: writes to read-only registers
        ev(0, 1'b1, 1'b1, "R7");
        wr(2'd1, 32'hFFFF_FFFF, "R7");
        wr(2'd2, 32'h0000_0000, "R7");
        wr(2'd1, 32'h0000_0000, "R7");
        rd_all("R7");

        // R10: indices past the last master
        for (int m = N; m < 8; m++) ev(m, 1'b1, 1'b1, "R10");
        rd_all("R10");

        // R9: last valid master and unused bits; read while writing
        ev(4, 1'b1, 1'b1, "R9");
        rd(2'd0, "R9"); rd(2'd2, "R9");
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 32'hFFFF_FFE1, "R9");
        rd(2'd0, "R9");
        cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R9");

        // R8: soft reset beats a coincident event; control reads zero
        for (int m = 0; m < N; m++) ev(m, m[0], 1'b0, "R8");
        rd(2'd1, "R8");
        cyc(1'b1, 2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 32'h0000_0001, "R8");
        rd_all("R8");
        wr(2'd3, 32'hFFFF_FFFE, "R8");
        rd(2'd3, "R8");

        // R3 / R4 pattern across all masters
        for (int m = 0; m < N; m++) ev(m, m[1], m[0], "R3");
        for (int m = 0; m < N; m++) ev(m, ~m[1], 1'b0, "R4");
        rd_all("R4");

        // R1: system reset mid-operation
        sys_rst = 1'b1;
        cyc(1'b1, 0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, '0, "R1");
        sys_rst = 1'b0;
        rd_all("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule